// File: doc/BRIEF.md
# Host Pipe Bank Status Tracker

This block keeps the live status of one host-side data pipe whose payload sits in one to three equal banks of a shared buffer RAM. It holds a byte count for the bank now in use, tells the user side whether another byte may be moved, names the current bank and counts how many banks are waiting for the packet engine. The count moves up or down according to the pipe direction. For an OUT pipe the user fills the bank and the engine drains it. For an IN pipe the engine fills the bank and the user drains it.

A configuration is captured when the allocate input goes high. The block checks that configuration against the bank and size limits and against the total buffer size, and the result stays visible while allocate is held high. While no valid configuration is held, the pipe is idle and every count stays at zero. The buffer RAM, the packet engine and the interrupt flags are outside the block. The received-stall and pipe-error flags come in as levels.

Top module: `pipe_bank_tracker`

## Requirements
- R1: After reset, `byte_cnt`, `cur_bank`, `busy_banks`, `cfg_ok` and `rw_ok` are all 0.
- R2: On an OUT pipe (`cfg_dir_in`=0 at allocation), each user write accepted while `rw_ok`=1 adds one to `byte_cnt`. Each `per_tx` strobe while the count is nonzero subtracts one. The count is visible on the following clock.
- R3: On an IN pipe (`cfg_dir_in`=1 at allocation), each `per_rx` strobe while the bank is not full adds one to `byte_cnt`. Each user read accepted while `rw_ok`=1 subtracts one.
- R4: The bank capacity is 8 shifted left by the size code (size 0 = 8 bytes, size 7 = 1024 bytes). `rw_ok` is 1 when a valid configuration is held and the current bank is below capacity (OUT pipe) or nonzero (IN pipe). Otherwise `rw_ok` is 0.
- R5: `rw_ok` is 0 in any cycle where `rx_stall` or `pipe_err` is 1.
- R6: On the clock where `cfg_alloc` is first seen high, `cfg_ok` takes 1 only if all three of these hold:
  - the bank code is between 1 and the bank maximum (3);
  - the size code is at most the size maximum (7);
  - banks × bank bytes is at most the RAM size (2048).

  `cfg_ok` returns to 0 on the clock after `cfg_alloc` is seen low. While `cfg_ok` is 0, the count, the bank number and the busy count are all held at 0.
- R7: The count never goes above capacity or below zero. A strobe that would do so has no effect. An increment and a decrement in the same cycle leave the count unchanged.
- R8: A `usr_done` strobe clears `byte_cnt` and moves `cur_bank` to the next bank, wrapping from the last configured bank to 0. It overrides any increment or decrement in that cycle.
- R9: `busy_banks` rises by one on a bank fill and falls by one on a bank drain, and stays between 0 and the configured bank count. A fill is `usr_done` for OUT and `eng_done` for IN. A drain is `eng_done` for OUT and `usr_done` for IN.
- R10: A user write or read issued while `rw_ok`=0 is ignored, and so is a strobe that belongs to the other direction (`usr_rd`/`per_rx` on OUT, `usr_wr`/`per_tx` on IN). The count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_alloc | input | 1 | Allocate level; its rising edge captures the configuration |
| cfg_dir_in | input | 1 | Pipe direction: 1 = IN, 0 = OUT |
| cfg_banks | input | 2 | Requested bank count code |
| cfg_size | input | 3 | Bank size code, bytes = 8 << code |
| usr_wr | input | 1 | User writes one byte (OUT) |
| usr_rd | input | 1 | User reads one byte (IN) |
| usr_done | input | 1 | User finished with the current bank |
| per_tx | input | 1 | Engine sent one byte to the peripheral (OUT) |
| per_rx | input | 1 | Engine received one byte from the peripheral (IN) |
| eng_done | input | 1 | Engine finished with a bank |
| rx_stall | input | 1 | Received-stall flag level |
| pipe_err | input | 1 | Pipe-error flag level |
| byte_cnt | output | 11 | Byte count of the current bank |
| rw_ok | output | 1 | User may move another byte |
| cfg_ok | output | 1 | Captured configuration is valid |
| cur_bank | output | 2 | Number of the current bank |
| busy_banks | output | 2 | Number of banks held by the engine side |

## Verification
The bench builds the block with its default parameters: an 11-bit count, three banks at most, size codes up to 7 and a 2048-byte buffer. With these values a request for three 1024-byte banks is rejected, while two 1024-byte banks fit exactly, so both sides of the RAM-size check can be reached. Eight-byte banks fill after eight writes, which keeps the full and empty limits, busy-count saturation and the bank wrap-around within a few cycles of each allocation.

// File: rtl/pbt_pkg.sv
package pbt_pkg;

  typedef enum logic {
    PIPE_OUT = 1'b0,
    PIPE_IN  = 1'b1
  } pipe_dir_e;

  // bytes held by one bank for a given size code
  function automatic logic [31:0] bank_bytes(input logic [31:0] code);
    return 32'd8 << code;
  endfunction

endpackage

// File: rtl/pbt_cfg_check.sv
module pbt_cfg_check
  import pbt_pkg::*;
#(
  parameter int SIZE_W    = 3,
  parameter int BANK_W    = 2,
  parameter int CNT_W     = 11,
  parameter int MAX_SIZE  = 7,
  parameter int MAX_BANKS = 3,
  parameter int RAM_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              dir_in,
  input  logic [BANK_W-1:0] banks,
  input  logic [SIZE_W-1:0] size,
  output logic              cfg_ok,
  output pipe_dir_e         dir_q,
  output logic [BANK_W-1:0] nb_q,
  output logic [CNT_W-1:0]  cap_q
);

  logic              alloc_q;
  logic              fits;
  logic              rise;
  logic [31:0]       total;
  logic              ok_n;
  pipe_dir_e         dir_n;
  logic [BANK_W-1:0] nb_n;
  logic [CNT_W-1:0]  cap_n;

  always_comb begin
    total = 32'(banks) * bank_bytes(32'(size));
    fits  = (banks != '0) && (32'(banks) <= 32'(MAX_BANKS)) &&
            (32'(size) <= 32'(MAX_SIZE)) && (total <= 32'(RAM_BYTES));
    rise  = alloc && !alloc_q;
    ok_n  = cfg_ok;
    dir_n = dir_q;
    nb_n  = nb_q;
    cap_n = cap_q;
    if (rise) begin
      ok_n  = fits;
      dir_n = dir_in ? PIPE_IN : PIPE_OUT;
      nb_n  = banks;
      cap_n = CNT_W'(bank_bytes(32'(size)));
    end else if (!alloc) begin
      ok_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc_q <= 1'b0;
      cfg_ok  <= 1'b0;
      dir_q   <= PIPE_OUT;
      nb_q    <= '0;
      cap_q   <= '0;
    end else begin
      alloc_q <= alloc;
      cfg_ok  <= ok_n;
      dir_q   <= dir_n;
      nb_q    <= nb_n;
      cap_q   <= cap_n;
    end
  end

  // R6: a low allocate level drops the valid flag on the next clock
  assert_alloc_low_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc |=> !cfg_ok);

  // R6: a valid configuration never carries a zero bank count
  assert_ok_has_banks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> (nb_q != '0) && (cap_q != '0));

endmodule

// File: rtl/pbt_byte_counter.sv
module pbt_byte_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  input  logic             dec,
  input  logic [CNT_W-1:0] cap,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             inc_ok;
  logic             dec_ok;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    inc_ok = inc && (cnt < cap);
    dec_ok = dec && (cnt != '0);
    cnt_n  = cnt;
    if (clear) begin
      cnt_n = '0;
    end else if (inc_ok && !dec_ok) begin
      cnt_n = cnt + ONE;
    end else if (dec_ok && !inc_ok) begin
      cnt_n = cnt - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  // R7: count stays within the bank capacity
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cap);

  // R2: the count moves by at most one byte per clock unless cleared
  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + ONE) ||
               (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/pbt_bank_ring.sv
module pbt_bank_ring #(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic              fill,
  input  logic              drain,
  input  logic [BANK_W-1:0] nb,
  output logic [BANK_W-1:0] cur,
  output logic [BANK_W-1:0] busy
);

  localparam logic [BANK_W-1:0] ONE = BANK_W'(1);

  logic              up;
  logic              down;
  logic [BANK_W-1:0] cur_n;
  logic [BANK_W-1:0] busy_n;

  always_comb begin
    up     = fill && (busy < nb);
    down   = drain && (busy != '0);
    cur_n  = cur;
    busy_n = busy;
    if (clear) begin
      cur_n  = '0;
      busy_n = '0;
    end else begin
      if (advance) cur_n = (cur == nb - ONE) ? '0 : cur + ONE;
      if (up && !down)      busy_n = busy + ONE;
      else if (down && !up) busy_n = busy - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= '0;
      busy <= '0;
    end else begin
      cur  <= cur_n;
      busy <= busy_n;
    end
  end

  // R8: current bank always names a configured bank
  assert_cur_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nb != '0) |-> (cur < nb));

  // R9: busy count never exceeds the configured banks
  assert_busy_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy <= nb);

endmodule

// File: rtl/pipe_bank_tracker.sv
module pipe_bank_tracker
  import pbt_pkg::*;
#(
  parameter int SIZE_W    = 3,
  parameter int BANK_W    = 2,
  parameter int CNT_W     = 11,
  parameter int MAX_SIZE  = 7,
  parameter int MAX_BANKS = 3,
  parameter int RAM_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_alloc,
  input  logic              cfg_dir_in,
  input  logic [BANK_W-1:0] cfg_banks,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              usr_wr,
  input  logic              usr_rd,
  input  logic              usr_done,
  input  logic              per_tx,
  input  logic              per_rx,
  input  logic              eng_done,
  input  logic              rx_stall,
  input  logic              pipe_err,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic              rw_ok,
  output logic              cfg_ok,
  output logic [BANK_W-1:0] cur_bank,
  output logic [BANK_W-1:0] busy_banks
);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  pipe_dir_e         dir_q;
  logic [BANK_W-1:0] nb_q;
  logic [CNT_W-1:0]  cap_q;

  pbt_cfg_check #(
    .SIZE_W(SIZE_W), .BANK_W(BANK_W), .CNT_W(CNT_W),
    .MAX_SIZE(MAX_SIZE), .MAX_BANKS(MAX_BANKS), .RAM_BYTES(RAM_BYTES)
  ) cfg_i (
    .clk(clk), .rst_n(rst_s), .alloc(cfg_alloc), .dir_in(cfg_dir_in),
    .banks(cfg_banks), .size(cfg_size), .cfg_ok(cfg_ok), .dir_q(dir_q),
    .nb_q(nb_q), .cap_q(cap_q)
  );

  logic is_in;
  logic blocked;
  logic cnt_inc;
  logic cnt_dec;
  logic cnt_clr;
  logic ring_clr;
  logic bank_fill;
  logic bank_drain;

  always_comb begin
    is_in   = (dir_q == PIPE_IN);
    blocked = rx_stall || pipe_err;
    rw_ok   = cfg_ok && !blocked &&
              (is_in ? (byte_cnt != '0) : (byte_cnt < cap_q));
    cnt_inc    = is_in ? per_rx : (usr_wr && rw_ok);
    cnt_dec    = is_in ? (usr_rd && rw_ok) : per_tx;
    cnt_clr    = !cfg_ok || usr_done;
    ring_clr   = !cfg_ok;
    bank_fill  = is_in ? eng_done : usr_done;
    bank_drain = is_in ? usr_done : eng_done;
  end

  pbt_byte_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_s), .clear(cnt_clr), .inc(cnt_inc),
    .dec(cnt_dec), .cap(cap_q), .cnt(byte_cnt)
  );

  pbt_bank_ring #(.BANK_W(BANK_W)) ring_i (
    .clk(clk), .rst_n(rst_s), .clear(ring_clr), .advance(usr_done),
    .fill(bank_fill), .drain(bank_drain), .nb(nb_q),
    .cur(cur_bank), .busy(busy_banks)
  );

  // R5: stall or error level blocks user access in the same cycle
  assert_stall_blocks_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (rx_stall || pipe_err) |-> !rw_ok);

  // R10: a refused OUT write leaves the count untouched
  assert_refused_write_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (cfg_ok && !is_in && usr_wr && !rw_ok && !per_tx && !usr_done)
      |=> (byte_cnt == $past(byte_cnt)));

  // R4: an OUT bank at capacity refuses writes
  assert_full_out_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (cfg_ok && !is_in && (byte_cnt == cap_q)) |-> !rw_ok);

endmodule

// File: tb/pipe_bank_tracker_tb.sv
module pipe_bank_tracker_tb_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_alloc, cfg_dir_in;
  logic [1:0] cfg_banks;
  logic [2:0] cfg_size;
  logic       usr_wr, usr_rd, usr_done, per_tx, per_rx, eng_done;
  logic       rx_stall, pipe_err;
  logic [10:0] byte_cnt;
  logic       rw_ok, cfg_ok;
  logic [1:0] cur_bank, busy_banks;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  pipe_bank_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_alloc(cfg_alloc), .cfg_dir_in(cfg_dir_in),
    .cfg_banks(cfg_banks), .cfg_size(cfg_size), .usr_wr(usr_wr),
    .usr_rd(usr_rd), .usr_done(usr_done), .per_tx(per_tx), .per_rx(per_rx),
    .eng_done(eng_done), .rx_stall(rx_stall), .pipe_err(pipe_err),
    .byte_cnt(byte_cnt), .rw_ok(rw_ok), .cfg_ok(cfg_ok),
    .cur_bank(cur_bank), .busy_banks(busy_banks)
  );

  // ---------------- behavioural reference ----------------
  int m_ok, m_dir, m_nb, m_cap, m_cnt, m_cur, m_busy, m_aq;
  int t_inc, t_dec, t_up, t_dn, t_rw;

  function automatic int m_fits(int b, int s);
    return (b >= 1 && b <= 3 && s <= 7 && b * (8 << s) <= 2048) ? 1 : 0;
  endfunction

  function automatic int m_rwok();
    if (m_ok == 0 || rx_stall || pipe_err) return 0;
    if (m_dir != 0) return (m_cnt != 0) ? 1 : 0;
    return (m_cnt < m_cap) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ok = 0; m_dir = 0; m_nb = 0; m_cap = 0;
      m_cnt = 0; m_cur = 0; m_busy = 0; m_aq = 0;
    end else begin
      t_rw = m_rwok();
      if (m_ok == 0) begin
        m_cnt = 0; m_cur = 0; m_busy = 0;
      end else begin
        if (m_dir != 0) begin
          t_inc = (per_rx && m_cnt < m_cap) ? 1 : 0;
          t_dec = (usr_rd && t_rw != 0) ? 1 : 0;
          t_up  = (eng_done && m_busy < m_nb) ? 1 : 0;
          t_dn  = (usr_done && m_busy > 0) ? 1 : 0;
        end else begin
          t_inc = (usr_wr && t_rw != 0) ? 1 : 0;
          t_dec = (per_tx && m_cnt > 0) ? 1 : 0;
          t_up  = (usr_done && m_busy < m_nb) ? 1 : 0;
          t_dn  = (eng_done && m_busy > 0) ? 1 : 0;
        end
        if (usr_done) begin
          m_cnt = 0;
          m_cur = (m_cur + 1) % m_nb;
        end else begin
          m_cnt = m_cnt + t_inc - t_dec;
        end
        m_busy = m_busy + t_up - t_dn;
      end
      if (cfg_alloc && m_aq == 0) begin
        m_ok  = m_fits(int'(cfg_banks), int'(cfg_size));
        m_dir = cfg_dir_in ? 1 : 0;
        m_nb  = int'(cfg_banks);
        m_cap = 8 << cfg_size;
      end else if (!cfg_alloc) begin
        m_ok = 0;
      end
      m_aq = cfg_alloc ? 1 : 0;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk(int'(byte_cnt),   m_cnt,    "R2/R3 byte count vs model");
    chk(int'(rw_ok),      m_rwok(), "R4/R5 access flag vs model");
    chk(int'(cfg_ok),     m_ok,     "R6 config flag vs model");
    chk(int'(cur_bank),   m_cur,    "R8 current bank vs model");
    chk(int'(busy_banks), m_busy,   "R9 busy banks vs model");
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      cmp_all();
    end
  endtask

  task automatic idle();
    usr_wr = 0; usr_rd = 0; usr_done = 0;
    per_tx = 0; per_rx = 0; eng_done = 0;
    rx_stall = 0; pipe_err = 0;
  endtask

  task automatic alloc(input logic d, input logic [1:0] b, input logic [2:0] s);
    cfg_alloc = 0; tick(2);
    cfg_dir_in = d; cfg_banks = b; cfg_size = s; cfg_alloc = 1;
    tick(1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 0; cfg_alloc = 0; cfg_dir_in = 0; cfg_banks = 0; cfg_size = 0;
    idle();
    repeat (3) @(negedge clk);
    chk(int'(byte_cnt), 0, "R1 reset byte count");
    chk(int'(cur_bank), 0, "R1 reset bank");
    chk(int'(busy_banks), 0, "R1 reset busy");
    chk(int'(cfg_ok), 0, "R1 reset cfg flag");
    chk(int'(rw_ok), 0, "R1 reset access flag");
    rst_n = 1;
    tick(4);

    // OUT pipe, two 8-byte banks
    alloc(1'b0, 2'd2, 3'd0);
    chk(int'(cfg_ok), 1, "R6 two 8-byte banks accepted");
    usr_wr = 1; tick(10); usr_wr = 0;
    chk(int'(byte_cnt), 8, "R10 writes past full ignored");
    chk(int'(rw_ok), 0, "R4 full OUT bank refuses");
    per_tx = 1; tick(3); per_tx = 0;
    chk(int'(byte_cnt), 5, "R2 sends drain count");
    usr_wr = 1; per_tx = 1; tick(1); usr_wr = 0; per_tx = 0;
    chk(int'(byte_cnt), 5, "R7 simultaneous up and down");
    rx_stall = 1; usr_wr = 1; tick(1);
    chk(int'(rw_ok), 0, "R5 stall blocks access");
    chk(int'(byte_cnt), 5, "R10 write under stall ignored");
    usr_wr = 0; rx_stall = 0;
    usr_rd = 1; per_rx = 1; tick(1); usr_rd = 0; per_rx = 0;
    chk(int'(byte_cnt), 5, "R10 IN strobes ignored on OUT");
    usr_done = 1; tick(1);
    chk(int'(cur_bank), 1, "R8 advance to bank 1");
    chk(int'(busy_banks), 1, "R9 one bank busy");
    chk(int'(byte_cnt), 0, "R8 done clears count");
    tick(1);
    chk(int'(cur_bank), 0, "R8 wrap to bank 0");
    tick(1); usr_done = 0;
    chk(int'(busy_banks), 2, "R9 busy saturates at bank count");
    eng_done = 1; tick(3); eng_done = 0;
    chk(int'(busy_banks), 0, "R9 drained to zero");

    // IN pipe, three 16-byte banks
    alloc(1'b1, 2'd3, 3'd1);
    per_rx = 1; tick(20); per_rx = 0;
    chk(int'(byte_cnt), 16, "R7 receive stops at capacity");
    usr_rd = 1; tick(4); usr_rd = 0;
    chk(int'(byte_cnt), 12, "R3 reads drain count");
    pipe_err = 1; usr_rd = 1; tick(1); usr_rd = 0;
    chk(int'(byte_cnt), 12, "R5 error blocks reads");
    pipe_err = 0;
    usr_rd = 1; tick(15); usr_rd = 0;
    chk(int'(byte_cnt), 0, "R10 reads past empty ignored");
    chk(int'(rw_ok), 0, "R4 empty IN bank refuses");
    eng_done = 1; tick(2); eng_done = 0;
    chk(int'(busy_banks), 2, "R9 IN fills");
    usr_done = 1; tick(3); usr_done = 0;
    chk(int'(cur_bank), 0, "R8 three-bank wrap");
    chk(int'(busy_banks), 0, "R9 IN releases");

    // configuration limits
    alloc(1'b0, 2'd3, 3'd7);
    chk(int'(cfg_ok), 0, "R6 3x1024 exceeds RAM");
    usr_wr = 1; usr_done = 1; tick(2); usr_wr = 0; usr_done = 0;
    chk(int'(byte_cnt), 0, "R6 idle pipe holds count");
    chk(int'(cur_bank), 0, "R6 idle pipe holds bank");
    alloc(1'b0, 2'd2, 3'd7);
    chk(int'(cfg_ok), 1, "R6 2x1024 fits RAM");
    alloc(1'b1, 2'd0, 3'd0);
    chk(int'(cfg_ok), 0, "R6 zero banks rejected");
    cfg_alloc = 0; tick(2);
    chk(int'(cfg_ok), 0, "R6 deallocation clears");

    // mixed traffic against the model
    for (int blk = 0; blk < 12; blk++) begin
      alloc(1'($urandom % 2), 2'($urandom % 4), 3'($urandom % 3));
      for (int c = 0; c < 250; c++) begin
        usr_wr   = 1'($urandom % 2);
        usr_rd   = 1'($urandom % 2);
        per_tx   = 1'($urandom % 3 == 0);
        per_rx   = 1'($urandom % 2);
        usr_done = 1'($urandom % 12 == 0);
        eng_done = 1'($urandom % 10 == 0);
        rx_stall = 1'($urandom % 16 == 0);
        pipe_err = 1'($urandom % 20 == 0);
        tick(1);
      end
      idle();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule